// File: doc/BRIEF.md
# Bidirectional GPIO Port with Change Interrupt

This block is an eight-pin general-purpose I/O port that software controls through a small register bus. Each pin is either an input or an output, set by a direction register. Output pins drive the value held in an output latch. The pad is modelled as three separate signal sets: drive data, drive enable, and a sampled input. A single global control bit, active low, turns on a weak pull-up on every pin that is configured as an input.

Pin inputs pass through a two-flop synchronizer before anything reads or compares them. The upper four pins can raise a change interrupt. When software reads or writes the port register, the block stores a snapshot of the synchronized inputs. After that, every upper pin that is configured as an input is compared against its snapshot bit. Any difference sets a sticky flag. While a difference remains, the flag is set again on every cycle, so software has to access the port register before a clear of the flag can take effect. A wake request is raised while the flag is set and the change interrupt is enabled.

The bus has no wait states. Read data is combinational during the cycle in which the read strobe is high, and writes and read side effects take effect on the next clock edge.

Top module: `gpio_chg_port`

## Requirements
- R1: After reset the direction register reads 0xFF, the output latch reads 0x00, and the control register reads 0x01: pull-ups disabled, interrupt disabled, flag clear. The wake output is low.
- R2: The bus address is two bits: 0 selects direction, 1 the output latch, 2 the port, 3 control. For each pin, a direction bit of 1 makes the pin an input with its drive enable low. A direction bit of 0 raises the drive enable, and the pin drives its latch bit. For example, writing 0xCF makes pins 4 and 5 outputs and all other pins inputs.
- R3: A read of address 1 returns the latched output value whatever level the pins carry.
- R4: Control bit 0 is the active-low global pull-up control. A pin's pull-up output is 1 only when that bit is 0 and the pin's direction bit is 1.
- R5: A read of address 2 returns the pin inputs as sampled through two clock stages. A pin change applied before edge k is visible on reads after edge k+1.
- R6: A write to address 2 updates the output latch, exactly as a write to address 1 does.
- R7: When any of pins 7 to 4 is an input and its synchronized value differs from the stored snapshot, the change flag (control bit 2) is 1 from the next edge onward.
- R8: Pins 3 to 0 never affect the change flag, and neither does any of pins 7 to 4 that is configured as an output.
- R9: A control write with bit 2 equal to 0 clears the flag only when no mismatch is present in that cycle. A read of address 2 stores the synchronized value it returns as the new snapshot.
- R10: A write to address 2 also stores the synchronized inputs as the new snapshot, which ends the mismatch.
- R11: The wake output is high exactly when the change flag is 1 and control bit 1 (interrupt enable) is 1.
- R12: A read of address 3 returns the flag in bit 2, the interrupt enable in bit 1, the pull-up control in bit 0, and zeros above. When no read is strobed, the read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle |
| pin_in | input | 8 | Raw pad input levels |
| pin_out | output | 8 | Pad drive data |
| pin_oe | output | 8 | Pad drive enable, 1 means drive |
| pin_pu | output | 8 | Weak pull-up enable per pin |
| chg_wake | output | 1 | Change wake request |

## Verification
The hardest case to reach is the sticky flag: a clear is written while an upper input still differs from its snapshot, the flag must stay set, and the same clear must work once a port access has refreshed the snapshot. The stimulus first takes a snapshot with a port read. It then toggles one upper input and waits out the synchronizer, writes the clear, and checks that the flag survives. Next it refreshes the snapshot, once with a port read and once with a port write, and checks that a second clear takes effect. Further sequences move the toggled pin to a lower pin or to an upper pin configured as an output. A long random run of mixed accesses and pin changes is then compared cycle by cycle against a behavioural model.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_DIR  = 2'd0,
    SEL_LAT  = 2'd1,
    SEL_PORT = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;

  localparam int unsigned CTRL_PUDIS = 0;
  localparam int unsigned CTRL_IEN   = 1;
  localparam int unsigned CTRL_FLAG  = 2;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] stage_d;
      if (s == 0) begin : g_first
        always_comb stage_d = d_i;
      end else begin : g_rest
        always_comb stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_chg_detect.sv
module gpio_chg_detect #(
  parameter int unsigned W  = 8,
  parameter int unsigned LO = 4
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] dir_i,
  input  logic         snap_upd_i,
  input  logic         clr_req_i,
  output logic         flag_o
);
  localparam int unsigned CW = W - LO;

  logic [CW-1:0] snap_q, snap_d;
  logic [CW-1:0] diff;
  logic          mism;
  logic          flag_q, flag_d;

  always_comb begin
    diff   = (sync_i[W-1:LO] ^ snap_q) & dir_i[W-1:LO];
    mism   = |diff;
    snap_d = snap_upd_i ? sync_i[W-1:LO] : snap_q;
    if (mism)           flag_d = 1'b1;
    else if (clr_req_i) flag_d = 1'b0;
    else                flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q <= '0;
      flag_q <= 1'b0;
    end else begin
      snap_q <= snap_d;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

  assert_mism_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    mism |=> flag_q);
  assert_flag_falls_on_clear_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(flag_q) |-> $past(clr_req_i));
  assert_snap_held_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    !snap_upd_i |=> $stable(snap_q));
endmodule

// File: rtl/gpio_chg_port.sv
module gpio_chg_port
  import gpio_chg_pkg::*;
#(
  parameter int unsigned W           = 8,
  parameter int unsigned CHG_LO      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pin_in,
  output logic [W-1:0]      pin_out,
  output logic [W-1:0]      pin_oe,
  output logic [W-1:0]      pin_pu,
  output logic              chg_wake
);
  logic rst_s1_q, rst_s2_q, rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_ni = rst_s2_q;

  logic [W-1:0] sync_val;

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_ni (rst_ni),
    .d_i    (pin_in),
    .q_o    (sync_val)
  );

  reg_sel_e sel;
  logic wr_dir, wr_lat, wr_port, wr_ctrl, rd_port;
  logic [W-1:0] dir_q, dir_d, lat_q, lat_d;
  logic pudis_q, pudis_d, ien_q, ien_d;
  logic flag, snap_upd, clr_req;

  always_comb begin
    sel     = reg_sel_e'(bus_addr);
    wr_dir  = bus_wr && (sel == SEL_DIR);
    wr_lat  = bus_wr && (sel == SEL_LAT);
    wr_port = bus_wr && (sel == SEL_PORT);
    wr_ctrl = bus_wr && (sel == SEL_CTRL);
    rd_port = bus_rd && (sel == SEL_PORT);

    dir_d   = wr_dir ? bus_wdata : dir_q;
    lat_d   = (wr_lat || wr_port) ? bus_wdata : lat_q;
    pudis_d = wr_ctrl ? bus_wdata[CTRL_PUDIS] : pudis_q;
    ien_d   = wr_ctrl ? bus_wdata[CTRL_IEN] : ien_q;

    snap_upd = rd_port || wr_port;
    clr_req  = wr_ctrl && !bus_wdata[CTRL_FLAG];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q   <= '1;
      lat_q   <= '0;
      pudis_q <= 1'b1;
      ien_q   <= 1'b0;
    end else begin
      dir_q   <= dir_d;
      lat_q   <= lat_d;
      pudis_q <= pudis_d;
      ien_q   <= ien_d;
    end
  end

  gpio_chg_detect #(.W(W), .LO(CHG_LO)) u_detect (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .sync_i     (sync_val),
    .dir_i      (dir_q),
    .snap_upd_i (snap_upd),
    .clr_req_i  (clr_req),
    .flag_o     (flag)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (sel)
        SEL_DIR:  bus_rdata = dir_q;
        SEL_LAT:  bus_rdata = lat_q;
        SEL_PORT: bus_rdata = sync_val;
        SEL_CTRL: begin
          bus_rdata[CTRL_PUDIS] = pudis_q;
          bus_rdata[CTRL_IEN]   = ien_q;
          bus_rdata[CTRL_FLAG]  = flag;
        end
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign pin_oe   = ~dir_q;
  assign pin_out  = lat_q;
  assign pin_pu   = dir_q & {W{~pudis_q}};
  assign chg_wake = flag & ien_q;

  assert_pu_never_on_output_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (pin_pu & pin_oe) == '0);
  assert_dir_holds_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    !wr_dir |=> $stable(pin_oe));
  assert_latch_holds_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    !(wr_lat || wr_port) |=> $stable(pin_out));
  assert_wake_needs_enable_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(chg_wake) |-> (flag && ien_q));
endmodule

// File: tb/gpio_chg_port_test.sv
module gpio_chg_port_test;
  localparam int PERIOD = 10;
  localparam int QTR    = PERIOD / 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = 8'd0;
  logic [7:0] pin_out, pin_oe, pin_pu;
  logic       chg_wake;

  always #(PERIOD/2) clk = ~clk;

  gpio_chg_port uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu),
    .chg_wake(chg_wake)
  );

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  string phase = "R1 reset";

  // behavioural reference state
  logic [7:0] m_dir = 8'hFF, m_lat = 8'h00, m_sync = 8'h00;
  logic [3:0] m_snap = 4'h0;
  bit m_pudis = 1, m_ien = 0, m_flag = 0;
  logic [7:0] pin_hist[$];
  int since_rel = 0;

  task automatic model_reset();
    m_dir = 8'hFF; m_lat = 8'h00; m_sync = 8'h00; m_snap = 4'h0;
    m_pudis = 1; m_ien = 0; m_flag = 0;
    pin_hist.delete();
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      since_rel = 0;
      model_reset();
    end else begin
      since_rel++;
      if (since_rel <= 2) begin
        model_reset();
      end else begin
        bit changed;
        bit clr;
        changed = 0;
        for (int i = 4; i < 8; i++)
          if (m_dir[i] && (m_sync[i] != m_snap[i-4])) changed = 1;
        clr = bus_wr && (bus_addr == 2'd3) && !bus_wdata[2];
        if (bus_wr) begin
          case (bus_addr)
            2'd0: m_dir = bus_wdata;
            2'd1: m_lat = bus_wdata;
            2'd2: begin m_lat = bus_wdata; m_snap = m_sync[7:4]; end
            default: begin m_pudis = bus_wdata[0]; m_ien = bus_wdata[1]; end
          endcase
        end
        if (bus_rd && bus_addr == 2'd2) m_snap = m_sync[7:4];
        if (changed) m_flag = 1;
        else if (clr) m_flag = 0;
        pin_hist.push_back(pin_in);
        while (pin_hist.size() > 2) pin_hist.pop_front();
        m_sync = (pin_hist.size() == 2) ? pin_hist[0] : 8'h00;
      end
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s [%s] t=%0t actual=%02h expected=%02h", tag, phase, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      logic [7:0] exp_rd, exp_pu;
      exp_rd = 8'h00;
      if (bus_rd) begin
        case (bus_addr)
          2'd0: exp_rd = m_dir;
          2'd1: exp_rd = m_lat;
          2'd2: exp_rd = m_sync;
          default: exp_rd = {5'b0, m_flag, m_ien, m_pudis};
        endcase
      end
      for (int i = 0; i < 8; i++) exp_pu[i] = m_dir[i] && !m_pudis;
      chk("R2 oe", pin_oe, ~m_dir);
      chk("R2 out", pin_out, m_lat);
      chk("R4 pullup", pin_pu, exp_pu);
      chk("R11 wake", {7'b0, chg_wake}, {7'b0, m_flag && m_ien});
      case (bus_addr)
        2'd0: chk("R12 R2 rdata", bus_rdata, exp_rd);
        2'd1: chk("R12 R3 rdata", bus_rdata, exp_rd);
        2'd2: chk("R12 R5 rdata", bus_rdata, exp_rd);
        default: chk("R12 R7 rdata", bus_rdata, exp_rd);
      endcase
    end
  end

  task automatic cyc(bit wr, bit rd, logic [1:0] a, logic [7:0] d);
    @(posedge clk); #QTR;
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 2'd0, 8'h00);
  endtask
  task automatic wr(logic [1:0] a, logic [7:0] d); cyc(1, 0, a, d); endtask
  task automatic rd(logic [1:0] a); cyc(0, 1, a, 8'h00); endtask
  task automatic pins(logic [7:0] v);
    @(posedge clk); #QTR; pin_in = v;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    mismatched++;
    $display("FAIL watchdog expired in phase %s", phase);
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    idle(3);
    #1 rst_n = 1'b1;
    idle(4);
    phase = "R1 R12 reset readback";
    rd(2'd0); rd(2'd1); rd(2'd3); rd(2'd2); idle(1);

    phase = "R2 R3 direction and latch";
    wr(2'd0, 8'hCF); wr(2'd1, 8'hA5);
    pins(8'h3C); idle(3);
    rd(2'd1); rd(2'd0); idle(1);

    phase = "R4 pull-up control";
    wr(2'd3, 8'h00); idle(1); rd(2'd3);
    wr(2'd0, 8'h0F); idle(1);
    wr(2'd3, 8'h01); idle(1);

    phase = "R5 synchronized port read";
    wr(2'd0, 8'hFF);
    pins(8'h96); rd(2'd2); rd(2'd2); rd(2'd2); idle(1);

    phase = "R6 port write sets latch";
    wr(2'd0, 8'h00); wr(2'd2, 8'h5A); rd(2'd1); idle(1);

    phase = "R7 R11 change on upper input";
    wr(2'd0, 8'hFF); pins(8'h00); idle(3);
    rd(2'd2); wr(2'd3, 8'h02); idle(2);
    pins(8'h80); idle(4); rd(2'd3);

    phase = "R9 clear blocked during mismatch";
    wr(2'd3, 8'h02); idle(1); rd(2'd3);
    rd(2'd2); wr(2'd3, 8'h02); idle(1); rd(2'd3); idle(2);

    phase = "R8 lower pins ignored";
    pins(8'h8F); idle(4); rd(2'd3);
    phase = "R8 upper output pins ignored";
    wr(2'd0, 8'h0F); pins(8'h4F); idle(4); rd(2'd3);
    pins(8'hFF); idle(4); rd(2'd3);

    phase = "R10 port write refreshes snapshot";
    wr(2'd0, 8'hFF); idle(4); rd(2'd3);
    wr(2'd3, 8'h02); idle(1); rd(2'd3);
    wr(2'd2, 8'h11); wr(2'd3, 8'h02); idle(1); rd(2'd3);
    pins(8'hDF); idle(4); rd(2'd3);
    wr(2'd2, 8'h22); wr(2'd3, 8'h00); idle(2); rd(2'd3);

    phase = "R1-random mixed traffic";
    phase = "random R5 R7 R9";
    for (int i = 0; i < 2000; i++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 2) pins(8'($urandom));
      else if (r < 5) cyc(0, 1, 2'($urandom), 8'h00);
      else if (r < 7) cyc(1, 0, 2'($urandom), 8'($urandom));
      else idle(1);
    end
    idle(3);
    finish_run();
  end
endmodule